// File: doc/BRIEF.md
# XOR Erasure Codec

This block lets a data word cross a lossy link that can drop a whole message but never corrupts one. On the transmit side, the word is zero-extended and cut into MSG_CNT-1 equal blocks. The block then sends MSG_CNT messages, one per clock, and each message carries a sequence tag. The two end messages carry the two end blocks unchanged. Each inner message carries the XOR of two adjacent blocks.

On the receive side, the block takes the messages that arrive, in any order, and records which tags it has seen. When the frame is closed with a flush strobe, it rebuilds the word if at most one message is missing. Reconstruction is sequential. An accumulator walks up from the lowest block to the gap, then down from the highest block to the gap, and writes one block per clock. A missing end message needs no special case, because one of the two walks then has no steps.

Top module: `xor_erasure_codec`

## Requirements
- R1: After reset, in_ready is 1 and tx_valid, out_done and out_err are 0.
- R2: BLK_W is ceil(DATA_W/(MSG_CNT-1)). Source block i is bits [i*BLK_W +: BLK_W] of the word zero-extended to (MSG_CNT-1)*BLK_W bits, so the top block carries the zero padding. At the defaults this is 6-bit blocks, with the top block holding word bits 15:12 under two zero bits.
- R3: The payload of the message tagged t is as follows: for t=0, block 0; for t=MSG_CNT-1, block MSG_CNT-2; for any other t, block t-1 XOR block t.
- R4: A word is accepted on a clock edge where in_valid and in_ready are both 1. The MSG_CNT messages then appear on consecutive cycles starting in the cycle after acceptance, with tx_tag (ceil(log2 MSG_CNT) bits) counting 0 up to MSG_CNT-1.
- R5: in_ready is 0 while messages are being emitted, and in_valid has no effect during that time. in_ready returns to 1 in the cycle after the last message, and tx_valid drops to 0 in that same cycle.
- R6: With all MSG_CNT messages received and no repeated tag, a flush rebuilds the original word.
- R7: With exactly one message missing, at any of the MSG_CNT positions, a flush rebuilds the original word. This holds whatever order the messages arrive in.
- R8: out_done is a one-cycle pulse visible MSG_CNT-1 clock edges after the edge that samples the flush. out_word is valid with it and holds its value until the next rebuild.
- R9: A flush with fewer than MSG_CNT-1 distinct tags received raises out_err for one cycle, in the cycle after the flush edge, and out_done does not rise.
- R10: If a tag is received twice, or a tag of MSG_CNT or more is received, within one frame, the flush raises out_err and does not produce out_done, even when enough tags are present.
- R11: Each flush clears the record of received tags and the error condition, so the next frame starts empty.
- R12: Messages and flushes presented while reconstruction is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Word to encode is present |
| in_ready | output | 1 | Encoder can take a word |
| in_word | input | DATA_W | Word to encode |
| tx_valid | output | 1 | Outgoing message present |
| tx_tag | output | TAG_W | Sequence tag of the outgoing message |
| tx_payload | output | BLK_W | Payload of the outgoing message |
| rx_valid | input | 1 | Incoming message present |
| rx_tag | input | TAG_W | Sequence tag of the incoming message |
| rx_payload | input | BLK_W | Payload of the incoming message |
| rx_flush | input | 1 | Closes the current receive frame |
| out_done | output | 1 | Rebuilt word is valid (one-cycle pulse) |
| out_err | output | 1 | Frame could not be rebuilt (one-cycle pulse) |
| out_word | output | DATA_W | Rebuilt word |

## Verification
Each result has a fixed due time. The first message is due in the cycle after the accepting edge, and the others follow one per cycle. The error pulse is due one edge after the flush. The done pulse is due exactly MSG_CNT-1 edges after the flush, which is three at the defaults, whatever the position of the gap. The bench drives inputs on falling edges and counts rising edges from the stimulus edge. It samples every output at the falling edge of the cycle where the value is due. It also checks the quiet cycles before and after each pulse, so a result that comes early or late fails.

// File: rtl/xec_pkg.sv
// Package shared by the erasure codec modules.
// Holds the reconstruction state type and a ceiling-division helper
// used to size blocks.
package xec_pkg;

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_LEFT  = 2'd1,
        RB_RIGHT = 2'd2
    } rb_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/xec_encoder.sv
// Encoder: latches one word, zero-extended to BLK_CNT*BLK_W bits, and emits
// MSG_CNT tagged messages on consecutive cycles. The payload of each message
// is the XOR of the blocks on either side of its tag position; a block that
// does not exist counts as zero.
// Assumes: the receiver of tx_* is always able to take a message (no backpressure).
module xec_encoder #(
    parameter int DATA_W  = 16,
    parameter int MSG_CNT = 4,
    parameter int BLK_W   = 6,
    parameter int TAG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_word,
    output logic              tx_valid,
    output logic [TAG_W-1:0]  tx_tag,
    output logic [BLK_W-1:0]  tx_payload
);
    localparam int BLK_CNT = MSG_CNT - 1;
    localparam int PAD_W   = BLK_CNT * BLK_W;
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(MSG_CNT - 1);

    logic             busy;
    logic [TAG_W-1:0] idx;
    logic [PAD_W-1:0] held;
    logic [BLK_W-1:0] left_blk;
    logic [BLK_W-1:0] right_blk;
    int               cur;

    // Accept a word when idle, then step the tag once per cycle until the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            held <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy <= 1'b1;
                idx  <= '0;
                held <= PAD_W'(in_word);
            end
        end else if (idx == LAST_TAG) begin
            busy <= 1'b0;
            idx  <= '0;
        end else begin
            idx <= idx + TAG_W'(1);
        end
    end

    // Select the two neighbouring blocks of the current tag (zero past either end).
    always_comb begin
        cur       = int'(idx);
        left_blk  = '0;
        right_blk = '0;
        if (cur > 0)
            left_blk = held[(cur - 1) * BLK_W +: BLK_W];
        if (cur < BLK_CNT)
            right_blk = held[cur * BLK_W +: BLK_W];
    end

    assign in_ready   = !busy;
    assign tx_valid   = busy;
    assign tx_tag     = idx;
    assign tx_payload = left_blk ^ right_blk;

    // R4
    first_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (tx_valid && tx_tag == '0));

    // R4
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_tag != LAST_TAG) |=> (tx_valid && tx_tag == $past(tx_tag) + TAG_W'(1)));

    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_tag == LAST_TAG) |=> (!tx_valid && in_ready));

endmodule

// File: rtl/xec_collector.sv
// Collector: stores incoming payloads by tag and keeps a mask of the tags seen.
// It also flags repeated or out-of-range tags. At a flush it either starts
// reconstruction (combinational start pulse) or reports an error one cycle
// later, and it always clears the frame.
// Assumes: everything on its inputs is ignored while the rebuilder is busy.
module xec_collector #(
    parameter int MSG_CNT = 4,
    parameter int BLK_W   = 6,
    parameter int TAG_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [TAG_W-1:0]         rx_tag,
    input  logic [BLK_W-1:0]         rx_payload,
    input  logic                     rx_flush,
    input  logic                     rb_busy,
    output logic [MSG_CNT-1:0]       mask,
    output logic [MSG_CNT*BLK_W-1:0] store,
    output logic                     start,
    output logic                     err
);
    logic bad;
    int   seen;

    // Count the distinct tags recorded in the current frame.
    always_comb begin
        seen = 0;
        for (int k = 0; k < MSG_CNT; k++)
            seen += int'(mask[k]);
    end

    // Record messages, mark protocol faults, and close the frame on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            store <= '0;
            bad   <= 1'b0;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (!rb_busy) begin
                if (rx_flush) begin
                    mask <= '0;
                    bad  <= 1'b0;
                    err  <= bad || (seen < MSG_CNT - 1);
                end else if (rx_valid) begin
                    if (int'(rx_tag) >= MSG_CNT || mask[rx_tag]) begin
                        bad <= 1'b1;
                    end else begin
                        mask[rx_tag] <= 1'b1;
                        store[int'(rx_tag) * BLK_W +: BLK_W] <= rx_payload;
                    end
                end
            end
        end
    end

    assign start = rx_flush && !rb_busy && !bad && (seen >= MSG_CNT - 1);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !rb_busy) |=> (mask == '0));

    // R12
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |=> ($stable(store) && $stable(mask)));

endmodule

// File: rtl/xec_rebuilder.sv
// Rebuilder: finds the missing position in the received mask (or takes the
// last position when nothing is missing) and recovers one source block per
// clock. It first accumulates upward from message 0 to the gap, then
// downward from message MSG_CNT-1 to the gap. It pulses done after
// MSG_CNT-1 steps.
// Assumes: start is raised only when at most one tag is missing.
module xec_rebuilder #(
    parameter int DATA_W  = 16,
    parameter int MSG_CNT = 4,
    parameter int BLK_W   = 6,
    parameter int TAG_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [MSG_CNT-1:0]       mask,
    input  logic [MSG_CNT*BLK_W-1:0] store,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        word
);
    import xec_pkg::*;

    localparam int BLK_CNT = MSG_CNT - 1;
    localparam int PAD_W   = BLK_CNT * BLK_W;
    localparam int LAST_B  = BLK_CNT - 1;

    rb_state_t        state;
    logic [TAG_W-1:0] idx;
    logic [TAG_W-1:0] gap;
    logic [TAG_W-1:0] gap_c;
    logic [BLK_W-1:0] acc;
    logic [BLK_W-1:0] val;
    logic [PAD_W-1:0] src;
    int               cur;

    // Locate the lowest missing tag; default to the last position if none is missing.
    always_comb begin
        gap_c = TAG_W'(MSG_CNT - 1);
        for (int k = MSG_CNT - 1; k >= 0; k--)
            if (!mask[k])
                gap_c = TAG_W'(k);
    end

    // Next recovered block for the current step of the active scan.
    always_comb begin
        cur = int'(idx);
        val = acc;
        if (state == RB_LEFT)
            val = (cur == 0) ? store[0 +: BLK_W]
                             : acc ^ store[cur * BLK_W +: BLK_W];
        else if (state == RB_RIGHT)
            val = (cur == LAST_B) ? store[BLK_CNT * BLK_W +: BLK_W]
                                  : acc ^ store[(cur + 1) * BLK_W +: BLK_W];
    end

    // Run the upward scan, then the downward scan, writing one block per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RB_IDLE;
            idx   <= '0;
            gap   <= '0;
            acc   <= '0;
            src   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RB_IDLE: begin
                    if (start) begin
                        gap <= gap_c;
                        if (gap_c == '0) begin
                            state <= RB_RIGHT;
                            idx   <= TAG_W'(LAST_B);
                        end else begin
                            state <= RB_LEFT;
                            idx   <= '0;
                        end
                    end
                end
                RB_LEFT: begin
                    src[cur * BLK_W +: BLK_W] <= val;
                    acc <= val;
                    if (cur == int'(gap) - 1) begin
                        if (int'(gap) == BLK_CNT) begin
                            state <= RB_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= RB_RIGHT;
                            idx   <= TAG_W'(LAST_B);
                        end
                    end else begin
                        idx <= idx + TAG_W'(1);
                    end
                end
                RB_RIGHT: begin
                    src[cur * BLK_W +: BLK_W] <= val;
                    acc <= val;
                    if (idx == gap) begin
                        state <= RB_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx - TAG_W'(1);
                    end
                end
                default: state <= RB_IDLE;
            endcase
        end
    end

    assign busy = (state != RB_IDLE);
    assign word = src[DATA_W-1:0];

    // Cycle counter kept only for the latency check below.
    logic [15:0] step_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_cnt <= '0;
        else if (state == RB_IDLE)
            step_cnt <= '0;
        else
            step_cnt <= step_cnt + 16'd1;
    end

    // R6
    start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ($countones(mask) >= MSG_CNT - 1));

    // R8
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && int'(step_cnt) == MSG_CNT - 1));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(word));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

// File: rtl/xor_erasure_codec.sv
// Top: a single-erasure codec that pairs the XOR-chained encoder with the
// collector and the two-ended rebuilder on the receive side. Both sides
// share DATA_W and MSG_CNT; block and tag widths are derived from them.
// Assumes: MSG_CNT >= 2, and messages arrive either whole or not at all.
module xor_erasure_codec #(
    parameter int DATA_W  = 16,
    parameter int MSG_CNT = 4,
    localparam int BLK_W  = xec_pkg::ceil_div(DATA_W, MSG_CNT - 1),
    localparam int TAG_W  = (MSG_CNT > 2) ? $clog2(MSG_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_word,
    output logic              tx_valid,
    output logic [TAG_W-1:0]  tx_tag,
    output logic [BLK_W-1:0]  tx_payload,
    input  logic              rx_valid,
    input  logic [TAG_W-1:0]  rx_tag,
    input  logic [BLK_W-1:0]  rx_payload,
    input  logic              rx_flush,
    output logic              out_done,
    output logic              out_err,
    output logic [DATA_W-1:0] out_word
);
    logic [MSG_CNT-1:0]       rx_mask;
    logic [MSG_CNT*BLK_W-1:0] rx_store;
    logic                     rb_start;
    logic                     rb_busy;

    xec_encoder #(
        .DATA_W(DATA_W), .MSG_CNT(MSG_CNT), .BLK_W(BLK_W), .TAG_W(TAG_W)
    ) u_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .tx_valid(tx_valid), .tx_tag(tx_tag), .tx_payload(tx_payload)
    );

    xec_collector #(
        .MSG_CNT(MSG_CNT), .BLK_W(BLK_W), .TAG_W(TAG_W)
    ) u_col (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_payload(rx_payload),
        .rx_flush(rx_flush), .rb_busy(rb_busy),
        .mask(rx_mask), .store(rx_store), .start(rb_start), .err(out_err)
    );

    xec_rebuilder #(
        .DATA_W(DATA_W), .MSG_CNT(MSG_CNT), .BLK_W(BLK_W), .TAG_W(TAG_W)
    ) u_rb (
        .clk(clk), .rst_n(rst_n),
        .start(rb_start), .mask(rx_mask), .store(rx_store),
        .busy(rb_busy), .done(out_done), .word(out_word)
    );

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_done && out_err));

endmodule

// File: tb/tb_xor_erasure_codec.sv
// Directed bench: one task per scenario. Expected messages are computed here
// from the requirements. Inputs change on falling edges, and outputs are
// sampled on falling edges.
module tb_xor_erasure_codec;
    localparam int N  = 16;
    localparam int M  = 4;
    localparam int BW = (N + M - 2) / (M - 1);
    localparam int TW = 2;
    localparam int PW = (M - 1) * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [N-1:0]  in_word = '0;
    logic          tx_valid;
    logic [TW-1:0] tx_tag;
    logic [BW-1:0] tx_payload;
    logic          rx_valid = 1'b0;
    logic [TW-1:0] rx_tag = '0;
    logic [BW-1:0] rx_payload = '0;
    logic          rx_flush = 1'b0;
    logic          out_done;
    logic          out_err;
    logic [N-1:0]  out_word;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    xor_erasure_codec #(.DATA_W(N), .MSG_CNT(M)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .tx_valid(tx_valid), .tx_tag(tx_tag), .tx_payload(tx_payload),
        .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_payload(rx_payload),
        .rx_flush(rx_flush),
        .out_done(out_done), .out_err(out_err), .out_word(out_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] blk(input logic [N-1:0] w, input int i);
        logic [PW-1:0] p;
        p = PW'(w);
        return p[i*BW +: BW];
    endfunction

    function automatic logic [BW-1:0] msg(input logic [N-1:0] w, input int t);
        if (t == 0)     return blk(w, 0);
        if (t == M - 1) return blk(w, M - 2);
        return blk(w, t - 1) ^ blk(w, t);
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: state straight after reset
    task automatic t_reset;
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
        chk(out_done == 1'b0 && out_err == 1'b0, "R1 done/err", {out_done, out_err}, 0);
    endtask

    // R2 R3 R4 R5: encode one word, checking each message when it is due
    task automatic t_encode(input logic [N-1:0] w);
        in_valid = 1'b1;
        in_word  = w;
        tick();
        for (int t = 0; t < M; t++) begin
            in_valid = (t < M - 1);
            in_word  = ~w;
            chk(tx_valid && tx_tag == TW'(t), "R4 tag sequence", {tx_valid, 8'(tx_tag)}, {1'b1, 8'(t)});
            chk(tx_payload == msg(w, t), "R3 payload", 32'(tx_payload), 32'(msg(w, t)));
            chk(in_ready == 1'b0, "R5 busy", 32'(in_ready), 0);
            tick();
        end
        in_valid = 1'b0;
        chk(!tx_valid && in_ready, "R5 frame end", {tx_valid, in_ready}, 32'b01);
        tick();
        chk(!tx_valid, "R5 extra word ignored", 32'(tx_valid), 0);
    endtask

    task automatic send(input int t, input logic [BW-1:0] p);
        rx_valid   = 1'b1;
        rx_tag     = TW'(t);
        rx_payload = p;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic flush;
        rx_flush = 1'b1;
        tick();
        rx_flush = 1'b0;
    endtask

    // R6 R7 R8: deliver a frame with one position dropped (or none), check the rebuild timing
    task automatic t_decode(input logic [N-1:0] w, input int drop, input bit rev, input string req);
        for (int k = 0; k < M; k++) begin
            int t;
            t = rev ? (M - 1 - k) : k;
            if (t != drop) send(t, msg(w, t));
        end
        flush();
        chk(!out_done && !out_err, {req, " quiet after flush"}, {out_done, out_err}, 0);
        for (int k = 1; k < M - 1; k++) begin
            tick();
            chk(!out_done, {req, " R8 early done"}, 32'(out_done), 0);
        end
        tick();
        chk(out_done == 1'b1, {req, " R8 done due"}, 32'(out_done), 1);
        chk(out_word == w, {req, " word"}, 32'(out_word), 32'(w));
        tick();
        chk(!out_done && out_word == w, "R8 pulse ends, word holds", {out_done, out_word}, {1'b0, w});
    endtask

    // R9 R10: a flush that must report an error and no rebuild
    task automatic expect_err(input string req);
        chk(out_err == 1'b1 && !out_done, req, {out_done, out_err}, 32'b01);
        for (int k = 0; k < M; k++) begin
            tick();
            chk(!out_err && !out_done, {req, " no later pulse"}, {out_done, out_err}, 0);
        end
    endtask

    task automatic t_too_few(input logic [N-1:0] w);
        send(0, msg(w, 0));
        send(3, msg(w, 3));
        flush();
        expect_err("R9 too few");
    endtask

    task automatic t_duplicate(input logic [N-1:0] w);
        send(0, msg(w, 0));
        send(1, msg(w, 1));
        send(1, msg(w, 1));
        send(2, msg(w, 2));
        send(3, msg(w, 3));
        flush();
        expect_err("R10 repeated tag");
    endtask

    // R12 R11: traffic during rebuild is dropped; the next frame starts empty
    task automatic t_busy_ignore(input logic [N-1:0] w);
        for (int t = 0; t < M; t++) send(t, msg(w, t));
        flush();
        rx_valid = 1'b1; rx_tag = '0; rx_payload = msg(w, 0);
        tick();
        rx_valid = 1'b0; rx_flush = 1'b1;
        tick();
        rx_flush = 1'b0;
        tick();
        chk(out_done && out_word == w, "R12 rebuild unaffected", {out_done, out_word}, {1'b1, w});
        tick();
        chk(!out_done && !out_err, "R12 busy flush ignored", {out_done, out_err}, 0);
        send(1, msg(w, 1));
        send(2, msg(w, 2));
        flush();
        expect_err("R12 R11 busy message not kept");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_encode(16'hA5C3);
        t_encode(16'hFFFF);
        chk(msg(16'hFFFF, M - 1) == 6'b001111, "R2 padding in top block", 32'(msg(16'hFFFF, M - 1)), 32'h0F);
        t_decode(16'hA5C3, -1, 1'b0, "R6 all present");
        for (int d = 0; d < M; d++) begin
            t_decode(16'h1234 ^ 16'(d * 16'h1111), d, 1'b0, "R7 one dropped");
            t_decode(16'h8001 + 16'(d), d, 1'b1, "R7 one dropped, reversed order");
        end
        t_too_few(16'h5A5A);
        t_decode(16'hFFFF, 2, 1'b0, "R11 after error frame");
        t_duplicate(16'h0F0F);
        t_decode(16'h0001, 0, 1'b1, "R11 after repeated tag");
        t_busy_ignore(16'hC0DE);
        t_decode(16'h7E57, 3, 1'b0, "R11 final frame");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule